// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This unit sits next to an ECC-protected on-chip memory whose words are 64 bits wide. The ECC decoder sends it single-cycle pulses: one kind for errors it could correct and another for errors it could not. Each pulse comes with the failing word's address offset and its 64-bit data. The unit records each kind of error in its own capture bank. Each bank holds the first failing event and keeps it until software acknowledges that error kind.

Software sees the unit through a plain 32-bit register port. Register writes take effect on the clock edge, and reads are combinational from the register state. The status register holds one flag per error kind, and software clears a flag by writing a one to it. The interrupt mask can only be changed by writing ones to a separate unmask register or a separate re-mask register. One interrupt line is the OR of all flags that are not masked. A control bit turns error recording on and off. The captured address is an 18-bit offset; software adds the memory's base address to it.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the status register (0x04) reads 0, the mask register (0x08) reads 0xC0, the control register (0x14) reads 0 and `irq` is low.
- R2: While recording is enabled, a `ce_pulse` sets status bit 6 and a `ue_pulse` sets status bit 7. The bit reads as set from the cycle after the pulse.
- R3: Writing to the status register clears each of bits 6 and 7 that has a one in the write data. A zero in the write data leaves that bit unchanged.
- R4: Writing ones to offset 0x0C clears the matching mask bits (6 and 7), which unmasks them. Writing ones to offset 0x10 sets them, which masks them. The mask register at 0x08 reads 1 for a masked bit and ignores writes. Offsets 0x0C and 0x10 read 0.
- R5: `irq` is high exactly when at least one status bit is set and its mask bit is 0.
- R6: The correctable bank reads its address offset at 0x1C, its data bits 31:0 at 0x20 and its data bits 63:32 at 0x24. The uncorrectable bank uses 0x34, 0x38 and 0x3C in the same way. The address offset is 18 bits wide and is zero-extended into bits 17:0. A bank loads on a recorded pulse only if its status flag was clear.
- R7: While a bank's status flag is set, later pulses of that kind do not change the bank's contents.
- R8: Bit 0 of the control register (0x14) can be written and read back. While it is 0, error pulses set no flag and load no bank.
- R9: If a recorded pulse and a write-one-to-clear of the same flag happen in the same cycle, the flag stays set.
- R10: A correctable pulse and an uncorrectable pulse in the same cycle set both flags and load both banks. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_pulse | input | 1 | Correctable error event, one cycle |
| ue_pulse | input | 1 | Uncorrectable error event, one cycle |
| err_ofs | input | 18 | Address offset of the failing word |
| err_data | input | 64 | Data word read at the failing address |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a second correctable event while the first is still flagged. A bank that loads on every pulse would report the newer address and data instead of the first ones. It also sends a pulse in the same cycle as a clear of the same flag. A design where the clear wins would drop that error with no interrupt. The bench sends pulses while recording is off, where a careless design would still latch them. It also moves the mask in both directions through the unmask and re-mask offsets, with flags set. A mask with reversed polarity, or a mask that can be written directly, would drive `irq` at the wrong time.

// File: rtl/ecc_cap_pkg.sv
// Package: shared constants for the ECC error capture unit.
// Assumes byte offsets on an 8-bit register address and 32-bit registers.
package ecc_cap_pkg;
    localparam int RA_W   = 8;
    localparam int CE_BIT = 6;
    localparam int UE_BIT = 7;
    localparam int NKIND  = 2;   // index 0 = correctable, 1 = uncorrectable

    localparam logic [RA_W-1:0] OFS_STATUS  = 8'h04;
    localparam logic [RA_W-1:0] OFS_MASK    = 8'h08;
    localparam logic [RA_W-1:0] OFS_UNMASK  = 8'h0C;
    localparam logic [RA_W-1:0] OFS_REMASK  = 8'h10;
    localparam logic [RA_W-1:0] OFS_CTRL    = 8'h14;
    localparam logic [RA_W-1:0] OFS_CE_ADDR = 8'h1C;
    localparam logic [RA_W-1:0] OFS_CE_DLO  = 8'h20;
    localparam logic [RA_W-1:0] OFS_CE_DHI  = 8'h24;
    localparam logic [RA_W-1:0] OFS_UE_ADDR = 8'h34;
    localparam logic [RA_W-1:0] OFS_UE_DLO  = 8'h38;
    localparam logic [RA_W-1:0] OFS_UE_DHI  = 8'h3C;
endpackage

// File: rtl/ecc_cap_bank.sv
// Module: one capture bank holding the address offset and data word of an event.
// Assumes the caller asserts load only for the event that must be kept.
module ecc_cap_bank #(
    parameter int OFS_W  = 18,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [OFS_W-1:0]  ofs_q,
    output logic [DATA_W-1:0] data_q
);
    // Purpose: store the event details when load is high, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            ofs_q  <= ofs_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/ecc_cap_irq.sv
// Module: error flags, interrupt mask and the interrupt output.
// Assumes set, clr, unmask and domask are one-cycle requests from the decode.
// A set beats a clear. The mask resets to all masked.
module ecc_cap_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] unmask,
    input  logic [N-1:0] domask,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         irq
);
    // Purpose: flag update in which a set has priority over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    // Purpose: mask update from the separate unmask and re-mask requests.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '1;
        else        mask <= (mask & ~unmask) | domask;
    end

    // Purpose: interrupt from any flag that is not masked.
    always_comb irq = |(flags & ~mask);
endmodule

// File: rtl/ecc_err_capture.sv
// Module: top of the ECC error capture and interrupt unit.
// Decodes register writes, owns the enable bit, runs one capture bank per
// error kind and drives the combinational read mux.
// Assumes DATA_W equals twice the register width.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int OFS_W  = 18,
    parameter int DATA_W = 64,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [OFS_W-1:0]  err_ofs,
    input  logic [DATA_W-1:0] err_data,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int HI_LSB = REG_W;

    logic              ecc_en_q;
    logic [NKIND-1:0]  pls, set_req, load, flags, mask_q;
    logic [NKIND-1:0]  clr_req, unmask_req, domask_req, wsel;
    logic [OFS_W-1:0]  bank_ofs  [NKIND];
    logic [DATA_W-1:0] bank_data [NKIND];
    logic              unused_wbits;

    assign pls  = {ue_pulse, ce_pulse};
    assign wsel = {reg_wdata[UE_BIT], reg_wdata[CE_BIT]};
    assign unused_wbits = ^{reg_wdata[REG_W-1:UE_BIT+1], reg_wdata[CE_BIT-1:1]};

    // Purpose: record events only while enabled; a bank loads only if its flag is clear.
    always_comb begin
        set_req = pls & {NKIND{ecc_en_q}};
        load    = set_req & ~flags;
    end

    // Purpose: turn register writes into clear, unmask and re-mask requests.
    always_comb begin
        clr_req    = (reg_we && reg_addr == OFS_STATUS) ? wsel : '0;
        unmask_req = (reg_we && reg_addr == OFS_UNMASK) ? wsel : '0;
        domask_req = (reg_we && reg_addr == OFS_REMASK) ? wsel : '0;
    end

    // Purpose: ECC enable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ecc_en_q <= 1'b0;
        else if (reg_we && reg_addr == OFS_CTRL) ecc_en_q <= reg_wdata[0];
    end

    for (genvar g = 0; g < NKIND; g++) begin : g_bank
        ecc_cap_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load[g]),
            .ofs_in  (err_ofs),
            .data_in (err_data),
            .ofs_q   (bank_ofs[g]),
            .data_q  (bank_data[g])
        );
    end

    ecc_cap_irq #(.N(NKIND)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (set_req),
        .clr    (clr_req),
        .unmask (unmask_req),
        .domask (domask_req),
        .flags  (flags),
        .mask   (mask_q),
        .irq    (irq)
    );

    // Purpose: combinational register read mux; unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: begin
                reg_rdata[CE_BIT] = flags[0];
                reg_rdata[UE_BIT] = flags[1];
            end
            OFS_MASK: begin
                reg_rdata[CE_BIT] = mask_q[0];
                reg_rdata[UE_BIT] = mask_q[1];
            end
            OFS_CTRL:    reg_rdata[0] = ecc_en_q;
            OFS_CE_ADDR: reg_rdata    = REG_W'(bank_ofs[0]);
            OFS_CE_DLO:  reg_rdata    = bank_data[0][REG_W-1:0];
            OFS_CE_DHI:  reg_rdata    = bank_data[0][HI_LSB +: REG_W];
            OFS_UE_ADDR: reg_rdata    = REG_W'(bank_ofs[1]);
            OFS_UE_DLO:  reg_rdata    = bank_data[1][REG_W-1:0];
            OFS_UE_DHI:  reg_rdata    = bank_data[1][HI_LSB +: REG_W];
            default:     reg_rdata    = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_capture_chk.sv
// Module: assertion checker for ecc_err_capture, attached with bind.
// Assumes the internal names flags, mask_q, ecc_en_q and g_bank[0].bank_i.ofs_q.
module ecc_err_capture_chk #(
    parameter int OFS_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_pulse,
    input logic             ue_pulse,
    input logic             ecc_en,
    input logic [1:0]       flags,
    input logic [1:0]       mask,
    input logic             irq,
    input logic [OFS_W-1:0] ce_ofs,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata
);
    p_ce_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en && ce_pulse |=> flags[0]);

    p_ue_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en && ue_pulse |=> flags[1]);

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] && !(ecc_en && ce_pulse) && reg_we && reg_addr == 8'h04 && reg_wdata[6]
        |=> !flags[0]);

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mask == 2'b11 |-> !irq);

    p_hold_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] |=> $stable(ce_ofs));

    p_disabled_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en && !flags[0] |=> !flags[0]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en && ue_pulse && reg_we && reg_addr == 8'h04 && reg_wdata[7] |=> flags[1]);
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.OFS_W(OFS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .ecc_en    (ecc_en_q),
    .flags     (flags),
    .mask      (mask_q),
    .irq       (irq),
    .ce_ofs    (g_bank[0].bank_i.ofs_q),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/ecc_err_capture_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: each read task pushes its expected value into a queue, and
// a monitor on the falling edge pops the entry and compares it with reg_rdata.
module ecc_err_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
    logic [17:0] err_ofs = '0;
    logic [63:0] err_data = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        rd_pend = 1'b0;
    int          n_tests = 0, n_fail = 0;

    typedef struct { logic [31:0] exp; string tag; } rd_item_t;
    rd_item_t sb[$];
    rd_item_t cur;

    always #2 clk = ~clk;

    ecc_err_capture dut_i (
        .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_ofs(err_ofs), .err_data(err_data), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Monitor: pop the expected item and compare it with the read data.
    always @(negedge clk) begin
        if (rd_pend && sb.size() > 0) begin
            cur = sb.pop_front();
            n_tests++;
            if (reg_rdata !== cur.exp) begin
                n_fail++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", cur.tag, reg_rdata, cur.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        reg_addr = a; sb.push_back(it); rd_pend = 1'b1;
        @(posedge clk); #1;
        rd_pend = 1'b0;
    endtask

    task automatic pulse(input logic c, input logic u, input logic [17:0] o, input logic [63:0] d);
        @(posedge clk); #1;
        ce_pulse = c; ue_pulse = u; err_ofs = o; err_data = d;
        @(posedge clk); #1;
        ce_pulse = 1'b0; ue_pulse = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, 32'h0,  "R1 status");
        rd(8'h08, 32'hC0, "R1 mask");
        rd(8'h14, 32'h0,  "R1 ctrl");
        chk_irq(1'b0, "R1 irq");

        // R8 pulses ignored while disabled
        pulse(1'b1, 1'b1, 18'h00555, 64'h1);
        rd(8'h04, 32'h0, "R8 status while disabled");
        rd(8'h1C, 32'h0, "R8 ce bank untouched");
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h1, "R8 ctrl readback");

        // R2 / R6 first correctable event
        pulse(1'b1, 1'b0, 18'h01234, 64'hDEADBEEF_01234567);
        rd(8'h04, 32'h40,       "R2 ce flag");
        rd(8'h1C, 32'h1234,     "R6 ce addr");
        rd(8'h20, 32'h01234567, "R6 ce data lo");
        rd(8'h24, 32'hDEADBEEF, "R6 ce data hi");
        chk_irq(1'b0, "R5 masked ce");

        // R4 / R5 unmask correctable, then a write to the mask register is ignored
        wr(8'h0C, 32'h40);
        rd(8'h08, 32'h80, "R4 mask after unmask");
        rd(8'h0C, 32'h0,  "R4 unmask reads zero");
        chk_irq(1'b1, "R5 unmasked ce");
        wr(8'h08, 32'hC0);
        rd(8'h08, 32'h80, "R4 mask is read-only");

        // R7 second event does not overwrite the first
        pulse(1'b1, 1'b0, 18'h00ABC, 64'h11112222_33334444);
        rd(8'h1C, 32'h1234,     "R7 ce addr held");
        rd(8'h24, 32'hDEADBEEF, "R7 ce data hi held");

        // R3 W1C: a zero leaves the flag, a one clears it
        wr(8'h04, 32'h80);
        rd(8'h04, 32'h40, "R3 zero bit no effect");
        wr(8'h04, 32'h40);
        rd(8'h04, 32'h0, "R3 ce cleared");
        chk_irq(1'b0, "R5 irq after clear");

        // R2 / R6 uncorrectable event with the largest offset
        pulse(1'b0, 1'b1, 18'h3FFFF, 64'hCAFEF00D_5555AAAA);
        rd(8'h04, 32'h80,       "R2 ue flag");
        rd(8'h34, 32'h3FFFF,    "R6 ue addr");
        rd(8'h38, 32'h5555AAAA, "R6 ue data lo");
        rd(8'h3C, 32'hCAFEF00D, "R6 ue data hi");
        chk_irq(1'b0, "R5 ue masked");
        wr(8'h0C, 32'h80);
        chk_irq(1'b1, "R5 ue unmasked");
        wr(8'h10, 32'h80);
        chk_irq(1'b0, "R4 ue re-masked");
        rd(8'h08, 32'h80, "R4 mask after remask");
        rd(8'h10, 32'h0,  "R4 remask reads zero");

        // R9 pulse and clear in the same cycle: the set wins
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h80;
        ue_pulse = 1'b1; err_ofs = 18'h00777; err_data = 64'h7;
        @(posedge clk); #1;
        reg_we = 1'b0; ue_pulse = 1'b0;
        rd(8'h04, 32'h80,  "R9 set wins");
        rd(8'h34, 32'h3FFFF, "R7 ue addr held");

        // R6 reload after clear
        wr(8'h04, 32'h80);
        pulse(1'b0, 1'b1, 18'h00010, 64'h00000001_80000000);
        rd(8'h34, 32'h10,       "R6 ue reload addr");
        rd(8'h38, 32'h80000000, "R6 ue reload lo");

        // R10 both kinds in one cycle, unmapped offset
        wr(8'h04, 32'hC0);
        pulse(1'b1, 1'b1, 18'h00200, 64'hA5A5A5A5_5A5A5A5A);
        rd(8'h04, 32'hC0,       "R10 both flags");
        rd(8'h1C, 32'h200,      "R10 ce bank");
        rd(8'h3C, 32'hA5A5A5A5, "R10 ue bank");
        rd(8'h18, 32'h0,        "R10 unmapped");
        chk_irq(1'b1, "R5 ce unmasked with both set");

        // R8 disabling stops further recording
        wr(8'h14, 32'h0);
        wr(8'h04, 32'hC0);
        pulse(1'b1, 1'b0, 18'h00001, 64'h2);
        rd(8'h04, 32'h0, "R8 disabled after clear");

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule